// File: doc/BRIEF.md
# FIFO Fill-Level Interrupt Status Unit

This block forms the interrupt status of a serial port that has a transmit FIFO and a receive FIFO. On every clock it compares the two FIFO fill counts against thresholds that software programs as eighths of the FIFO depth. It also latches a receive-idle timeout event and four per-character error pulses. The result appears in three views of one 11-bit status word: a raw view, a mask, and a masked view that drives a single interrupt line.

Software configures the unit through a small write port with three addresses: the level-select register, the mask register and the clear register. The level bits follow their comparison with no software action. The timeout and error bits stay set until software writes ones to the matching positions of the clear register. The depth parameter sets 16 or 32 entries, and every threshold scales with it.

Top module: `fifo_irq_status`

## Requirements
- R1: While reset is asserted, rawStat, maskStat and irqOut are all zero, and both threshold codes return to 0.
- R2: The level-select register is written with cfgAddr=0. cfgWrData[5:3] holds the receive code. Codes 0,1,2,3,4 select a threshold of 1/8, 2/8, 4/8, 6/8 and 7/8 of DEPTH. rawStat[4] is set when rxFill >= threshold. The bit is registered: it reflects the fill count and the code present before the same rising edge.
- R3: cfgWrData[2:0] of the level-select write holds the transmit code, decoded with the same table. rawStat[5] is set when txFill <= threshold, and is registered the same way as R2.
- R4: Codes 5, 6 and 7 behave exactly as code 2 (half of DEPTH) for both directions.
- R5: rawStat[4] and rawStat[5] clear by themselves once their comparison fails. A clear-register write has no effect on them.
- R6: A one-cycle pulse on rxIdleEvt, frameErr, parityErr, breakErr or overrunErr sets rawStat bit 6, 7, 8, 9 or 10 respectively at the next rising edge. The bit then stays set.
- R7: A write with cfgAddr=2 clears each sticky raw bit whose cfgWrData bit is 1 and leaves the others unchanged. If an event and a clear hit the same bit in the same cycle, the event wins and the bit stays set.
- R8: A write with cfgAddr=1 loads the 11-bit mask. maskStat equals rawStat AND mask in the same cycle.
- R9: irqOut is 1 exactly when maskStat is non-zero.
- R10: rawStat[3:0] is always zero. A write with cfgAddr=3 changes no state.
- R11: All thresholds scale with DEPTH: for DEPTH=32, code 4 selects 28 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | 0 level select, 1 mask, 2 clear, 3 unused |
| cfgWrData | input | 11 | Write data |
| rxFill | input | $clog2(DEPTH)+1 | Receive FIFO fill count |
| txFill | input | $clog2(DEPTH)+1 | Transmit FIFO fill count |
| rxIdleEvt | input | 1 | Receive-idle timeout pulse |
| frameErr | input | 1 | Framing error pulse |
| parityErr | input | 1 | Parity error pulse |
| breakErr | input | 1 | Break error pulse |
| overrunErr | input | 1 | Overrun error pulse |
| rawStat | output | 11 | Raw status |
| maskStat | output | 11 | Masked status |
| irqOut | output | 1 | OR of the masked status |

## Verification
For every code from 0 to 7, the threshold comparators are swept over every fill count from empty to full, on a 16-entry instance and a 32-entry instance at the same time. This sweep exposes a wrong entry in the eighths table, an off-by-one in the >= or <= comparison, a swapped receive or transmit field, and a depth that does not scale. Because the sweep raises the count, it also drives the level bits through both of their edges with no write, which shows that they clear by themselves. Separate single-pulse patterns on the error inputs separate sticky holding, selective clearing, and the event-over-clear priority. Mask patterns then tell the raw view apart from the masked view and from the interrupt line.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int STAT_W = 11;
  localparam int BIT_RX_LVL = 4;
  localparam int BIT_TX_LVL = 5;
  localparam int BIT_STICKY0 = 6;
  localparam int N_STICKY = 5;

  typedef enum logic [1:0] {
    ADDR_LEVEL = 2'd0,
    ADDR_MASK  = 2'd1,
    ADDR_CLEAR = 2'd2,
    ADDR_NONE  = 2'd3
  } cfgAddr_e;

  typedef struct packed {
    logic              lvlLoad;
    logic              maskLoad;
    logic              clrEn;
    logic [STAT_W-1:0] data;
  } ctrlStrobe_t;
endpackage

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fifo_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgAddr,
  input  logic [STAT_W-1:0] cfgWrData,
  output ctrlStrobe_t       strobe
);
  cfgAddr_e addrDec;

  always_comb begin
    addrDec         = cfgAddr_e'(cfgAddr);
    strobe.lvlLoad  = cfgWrEn && (addrDec == ADDR_LEVEL);
    strobe.maskLoad = cfgWrEn && (addrDec == ADDR_MASK);
    strobe.clrEn    = cfgWrEn && (addrDec == ADDR_CLEAR);
    strobe.data     = cfgWrData;
  end

  // R10: the unused address raises no strobe; at most one strobe per cycle
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.lvlLoad, strobe.maskLoad, strobe.clrEn}));
  a_r10_unused_addr: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgAddr == 2'd3) |-> !(strobe.lvlLoad || strobe.maskLoad || strobe.clrEn));
endmodule

// File: rtl/fifo_irq_datapath.sv
module fifo_irq_datapath
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [CW-1:0]     rxFill,
  input  logic [CW-1:0]     txFill,
  input  logic              rxIdleEvt,
  input  logic              frameErr,
  input  logic              parityErr,
  input  logic              breakErr,
  input  logic              overrunErr,
  output logic [STAT_W-1:0] rawStat,
  output logic [STAT_W-1:0] maskStat
);
  logic [2:0]          rxCode, txCode;
  logic [STAT_W-1:0]   maskQ;
  logic [1:0]          lvlQ;
  logic [N_STICKY-1:0] stickyQ;
  logic [N_STICKY-1:0] evtVec;
  logic [CW-1:0]       rxThr, txThr;

  function automatic logic [CW-1:0] thrOf(input logic [2:0] code);
    case (code)
      3'd0:    thrOf = CW'(DEPTH / 8);
      3'd1:    thrOf = CW'(DEPTH / 4);
      3'd3:    thrOf = CW'(DEPTH * 3 / 4);
      3'd4:    thrOf = CW'(DEPTH * 7 / 8);
      default: thrOf = CW'(DEPTH / 2);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxCode <= '0;
      txCode <= '0;
      maskQ  <= '0;
    end else begin
      if (strobe.lvlLoad) begin
        rxCode <= strobe.data[5:3];
        txCode <= strobe.data[2:0];
      end
      if (strobe.maskLoad) maskQ <= strobe.data;
    end
  end

  always_comb begin
    rxThr = thrOf(rxCode);
    txThr = thrOf(txCode);
  end

  always_ff @(posedge clk) begin
    if (!rstN) lvlQ <= '0;
    else begin
      lvlQ[0] <= (rxFill >= rxThr);
      lvlQ[1] <= (txFill <= txThr);
    end
  end

  assign evtVec = {overrunErr, breakErr, parityErr, frameErr, rxIdleEvt};

  for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (!rstN)                                      stickyQ[i] <= 1'b0;
      else if (evtVec[i])                             stickyQ[i] <= 1'b1;
      else if (strobe.clrEn && strobe.data[BIT_STICKY0+i]) stickyQ[i] <= 1'b0;
    end
  end

  assign rawStat  = {stickyQ, lvlQ, 4'b0000};
  assign maskStat = rawStat & maskQ;

  a_r2_full_rx: assert property (@(posedge clk) disable iff (!rstN)
    (rxFill == CW'(DEPTH)) |=> rawStat[BIT_RX_LVL]);
  a_r3_empty_tx: assert property (@(posedge clk) disable iff (!rstN)
    (txFill == '0) |=> rawStat[BIT_TX_LVL]);
  a_r6_frame_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rawStat[7] && !(strobe.clrEn && strobe.data[7])) |=> rawStat[7]);
  a_r6_overrun_set: assert property (@(posedge clk) disable iff (!rstN)
    overrunErr |=> rawStat[10]);
  a_r7_parity_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrEn && strobe.data[8] && !parityErr) |=> !rawStat[8]);
  a_r10_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    rawStat[3:0] == 4'b0000);
endmodule

// File: rtl/fifo_irq_status.sv
module fifo_irq_status
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgAddr,
  input  logic [STAT_W-1:0] cfgWrData,
  input  logic [CW-1:0]     rxFill,
  input  logic [CW-1:0]     txFill,
  input  logic              rxIdleEvt,
  input  logic              frameErr,
  input  logic              parityErr,
  input  logic              breakErr,
  input  logic              overrunErr,
  output logic [STAT_W-1:0] rawStat,
  output logic [STAT_W-1:0] maskStat,
  output logic              irqOut
);
  ctrlStrobe_t strobe;

  fifo_irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .strobe(strobe)
  );

  fifo_irq_datapath #(.DEPTH(DEPTH), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxFill(rxFill), .txFill(txFill),
    .rxIdleEvt(rxIdleEvt), .frameErr(frameErr), .parityErr(parityErr),
    .breakErr(breakErr), .overrunErr(overrunErr),
    .rawStat(rawStat), .maskStat(maskStat)
  );

  assign irqOut = |maskStat;

  a_r9_irq_match: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (maskStat != '0));
  a_r8_masked_subset: assert property (@(posedge clk) disable iff (!rstN)
    (maskStat & ~rawStat) == '0);
endmodule

// File: tb/sim_fifo_irq_status.sv
module sim_fifo_irq_status;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgAddr = 2'd0;
  logic [10:0] cfgWrData = '0;
  logic [4:0] rxFill = '0, txFill = '0;
  logic [5:0] rxFill1 = '0, txFill1 = '0;
  logic rxIdleEvt = 0, frameErr = 0, parityErr = 0, breakErr = 0, overrunErr = 0;
  logic [10:0] rawStat, maskStat, rawStat1, maskStat1;
  logic irqOut, irqOut1;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fifo_irq_status #(.DEPTH(16)) u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .rxFill(rxFill), .txFill(txFill), .rxIdleEvt(rxIdleEvt), .frameErr(frameErr),
    .parityErr(parityErr), .breakErr(breakErr), .overrunErr(overrunErr),
    .rawStat(rawStat), .maskStat(maskStat), .irqOut(irqOut));

  fifo_irq_status #(.DEPTH(32)) u1 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .rxFill(rxFill1), .txFill(txFill1), .rxIdleEvt(1'b0), .frameErr(1'b0),
    .parityErr(1'b0), .breakErr(1'b0), .overrunErr(1'b0),
    .rawStat(rawStat1), .maskStat(maskStat1), .irqOut(irqOut1));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [10:0] d);
    cfgWrEn = 1; cfgAddr = a; cfgWrData = d;
    tick();
    cfgWrEn = 0;
  endtask

  function automatic int thr(input int depth, input int code);
    int e;
    case (code)
      0: e = 1; 1: e = 2; 3: e = 6; 4: e = 7;
      default: e = 4;
    endcase
    return depth * e / 8;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R1: reset state
    chk("R1 raw", rawStat, 0);
    chk("R1 mask", maskStat, 0);
    chk("R1 irq", irqOut, 0);
    rstN = 1;
    tick();

    // R2 R3 R4 R5 R11 sweeps over codes and fills
    for (int code = 0; code < 8; code++) begin
      wr(2'd0, 11'((code << 3) | code));
      for (int f = 0; f <= 32; f++) begin
        int f16;
        f16 = (f > 16) ? 16 : f;
        rxFill = 5'(f16); txFill = 5'(f16);
        rxFill1 = 6'(f); txFill1 = 6'(f);
        tick();
        // R2 R4 receive level, R11 scaled depth
        chk("R2/R4 rx16", rawStat[4], int'(f16 >= thr(16, code)));
        chk("R11 rx32", rawStat1[4], int'(f >= thr(32, code)));
        // R3 R5 transmit level drops by itself as fill rises
        chk("R3/R5 tx16", rawStat[5], int'(f16 <= thr(16, code)));
        chk("R11 tx32", rawStat1[5], int'(f <= thr(32, code)));
        chk("R10 low bits", rawStat[3:0], 0);
      end
    end

    // R6 sticky error bits
    rxFill = 0; txFill = 16;  // rx level 0, tx level 0 (code 7 -> 8)
    tick();
    frameErr = 1; tick(); frameErr = 0;
    chk("R6 frame set", rawStat, 11'h080);
    repeat (3) tick();
    chk("R6 frame held", rawStat, 11'h080);
    rxIdleEvt = 1; parityErr = 1; breakErr = 1; overrunErr = 1; tick();
    rxIdleEvt = 0; parityErr = 0; breakErr = 0; overrunErr = 0;
    chk("R6 all sticky", rawStat, 11'h7C0);
    // R7 selective clear
    wr(2'd2, 11'h180);
    chk("R7 clear frame+parity", rawStat, 11'h640);
    // R7 event wins over clear
    breakErr = 1;
    wr(2'd2, 11'h200);
    breakErr = 0;
    chk("R7 event wins", rawStat, 11'h640);
    // R5 clear write does not touch level bits
    txFill = 0; tick();
    wr(2'd2, 11'h030);
    chk("R5 level kept", rawStat, 11'h660);
    // R8 mask
    wr(2'd1, 11'h020);
    chk("R8 masked tx", maskStat, 11'h020);
    chk("R9 irq on", irqOut, 1);
    // R10 address 3 ignored
    wr(2'd3, 11'h7FF);
    chk("R10 mask unchanged", maskStat, 11'h020);
    chk("R10 raw unchanged", rawStat, 11'h660);
    wr(2'd1, 11'h080);
    chk("R8 masked none", maskStat, 0);
    chk("R9 irq off", irqOut, 0);
    wr(2'd1, 11'h7FF);
    chk("R8 full mask", maskStat, 11'h660);
    wr(2'd2, 11'h7FF);
    txFill = 16; tick(); tick();
    chk("R7 all cleared", rawStat, 0);
    chk("R9 irq cleared", irqOut, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule